// File: doc/BRIEF.md
# Glitch-Free Clock Selector with Half-Step Divider

This block produces one root clock from a set of free-running input clocks. It gates one selected input through and divides it by a ratio that moves in half steps. The output frequency is twice the selected input frequency divided by (code + 1). Software sees two 32-bit registers behind a simple synchronous port, clocked by a separate bus clock. A configuration register holds a staged source index and divider code. A command register carries three bits: a commit request, a pending-change flag and a root-stopped status.

A new setting has no effect when it is written. It takes effect only when software sets the commit bit. The block then stops the current input during its low phase and waits until that stop is seen in the bus domain. It loads the new divider code while no clock reaches the divider, and releases the new input through a synchronizer in that input's own domain. It clears the commit bit once the new input is confirmed running. Configuration writes that arrive while a commit is in flight stay staged for the next commit. No data stream passes through the block, so every pin is a plain control, status or clock pin and there is no valid/ready back-pressure.

Top module: `cmux_root`

## Requirements
- R1: The command register sits at byte address 0x0. Bit 0 is the commit request, bit 4 is the pending flag and bit 31 is root-stopped; all other bits read 0. The configuration register sits at 0x4, with the divider code in bits [4:0] and the source index in bits [10:8]; all other bits read 0 and ignore writes. Read data appears on `reg_rdata` the cycle after `reg_rd`. Any other address reads 0, and writes to it change nothing.
- R2: After reset the commit and pending bits are 0 and the configuration reads source 0 with divider code 1. Root-stopped reads 1 only until source 0 is gated through, then 0. The output then runs at the source 0 frequency.
- R3: A configuration write updates the readback and sets the pending bit. It leaves the output frequency unchanged.
- R4: Writing 1 to command bit 0 starts a commit. The bit reads 1 until the new source and divider are in effect, then clears by itself. Writing 0 to it has no effect.
- R5: With effective code d and source period T, the output period is (d+1)·T/2. This holds for odd d+1 as well, for example 1.5·T for d = 2.
- R6: Code 0 behaves as code 1 (pass-through). The all-ones code is not a valid ratio and behaves as the code one below it.
- R7: A switch is break-before-make. At most one input is requested or open at any time, and root-stopped reads 1 in the gap between the old input stopping and the new one starting.
- R8: While a commit is in flight, configuration writes go only to the staged copy and command writes are ignored. When that commit ends, the output follows the setting captured at the commit, the pending bit still reads 1, and the later value applies at the next commit.
- R9: A commit with no configuration write after its start leaves the pending bit at 0 when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the register port and switch control |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | NSRC | Free-running candidate input clocks |
| reg_wr | input | 1 | Write strobe, sampled on `clk` |
| reg_rd | input | 1 | Read strobe, data returned the next cycle |
| reg_addr | input | ADDR_W | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| clk_out | output | 1 | Divided root clock |

## Verification
A divider counter that falls out of step with its partner edge domain shows up as an irregular or wrong `clk_out` period within two output periods. The bench therefore measures the spacing of rising edges after each commit, for both even and odd (d+1). A switch sequence stuck in one of its phases leaves command bit 0 set forever, and a missed stop leaves two inputs open at once. The first appears within a few input periods as a commit that never completes. The second is caught by the bound checker in the bus cycle where the synchronized acknowledgements overlap. A stale pending or staged value is visible on the very next register read.

// File: rtl/cmux_pkg.sv
package cmux_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned CMD_OFS       = 0;
  localparam int unsigned CFG_OFS       = 4;
  localparam int unsigned CMD_UPD_BIT   = 0;
  localparam int unsigned CMD_DIRTY_BIT = 4;
  localparam int unsigned CMD_OFF_BIT   = 31;

  // switch sequence: running, stopping old input, loading, starting new input
  typedef enum logic [1:0] {ST_RUN, ST_OFF, ST_LOAD, ST_ON} sw_state_e;
endpackage

// File: rtl/cmux_gate.sv
// One input lane: the request is resynchronized on rising edges of the
// lane clock and the enable changes only on falling edges, so the gated
// clock can only start or stop while it is low.
module cmux_gate (
  input  logic sclk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_ack,
  output logic gclk
);
  logic s1, s2;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= en_req;
      s2 <= s1;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) en_ack <= 1'b0;
    else        en_ack <= s2;
  end

  assign gclk = sclk & en_ack;
endmodule

// File: rtl/cmux_hdiv.sv
// Half-step divider: period = (code+1) half-cycles of the input clock.
// Output edges sit at half-cycle positions k*N and k*N + N/2 (N = code+1).
// A rising-edge counter toggles tp on even positions, a falling-edge
// counter toggles tn on odd positions; the output is their XOR.
module cmux_hdiv #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_in,
  input  logic             arst_n,
  input  logic [DIV_W-1:0] code,
  output logic             clk_o
);
  localparam int unsigned CW = DIV_W + 1;
  localparam int unsigned PW = DIV_W + 2;

  logic [CW-1:0] n_len, n_last;
  logic [PW-1:0] pos_h, pos_n, pos_nh;
  logic [CW-1:0] pc, nc;
  logic          tp, tn;

  assign n_len  = CW'(code) + CW'(1);
  assign n_last = n_len - CW'(1);
  assign pos_h  = PW'(n_len >> 1);
  assign pos_n  = PW'(n_len);
  assign pos_nh = pos_n + pos_h;

  function automatic logic is_edge(input logic [PW-1:0] p,
                                   input logic [PW-1:0] h,
                                   input logic [PW-1:0] n,
                                   input logic [PW-1:0] nh);
    return (p == '0) || (p == h) || (p == n) || (p == nh);
  endfunction

  always_ff @(posedge clk_in or negedge arst_n) begin
    if (!arst_n) begin
      pc <= '0;
      tp <= 1'b0;
    end else begin
      pc <= (pc >= n_last) ? '0 : pc + CW'(1);
      tp <= tp ^ is_edge({pc, 1'b0}, pos_h, pos_n, pos_nh);
    end
  end

  always_ff @(negedge clk_in or negedge arst_n) begin
    if (!arst_n) begin
      nc <= '0;
      tn <= 1'b0;
    end else begin
      nc <= (nc >= n_last) ? '0 : nc + CW'(1);
      tn <= tn ^ is_edge({nc, 1'b1}, pos_h, pos_n, pos_nh);
    end
  end

  assign clk_o = tp ^ tn;
endmodule

// File: rtl/cmux_regs.sv
module cmux_regs
  import cmux_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned DIV_SH = 0,
  parameter int unsigned SRC_SH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]   ack_raw,
  output logic [NSRC-1:0]   en_req,
  output logic [NSRC-1:0]   ack_s,
  output logic [DIV_W-1:0]  act_div,
  output logic              hold,
  output logic              upd,
  output logic              dirty,
  output logic              root_off
);
  localparam int unsigned SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned SRC_SPAN = 1 << SRC_W;

  sw_state_e        state;
  logic [NSRC-1:0]  ack_m;
  logic [SRC_W-1:0] sh_src, nsrc, act_src;
  logic [DIV_W-1:0] sh_div, ndiv;
  logic             wrs;
  logic             wr_cmd, wr_cfg, start, done, run_phase;
  logic [SRC_SPAN-1:0] ack_x, vmask;
  logic [REG_W-1:0] cmd_v, cfg_v;
  logic             unused_wd;

  assign unused_wd = ^reg_wdata;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] c);
    if (c == '0) return DIV_W'(1);
    if (&c)      return c - DIV_W'(1);
    return c;
  endfunction

  // acknowledgements from the lane domains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= '0;
      ack_s <= '0;
    end else begin
      ack_m <= ack_raw;
      ack_s <= ack_m;
    end
  end

  generate
    for (genvar i = 0; i < SRC_SPAN; i++) begin : g_pad
      if (i < NSRC) begin : g_real
        assign ack_x[i] = ack_s[i];
        assign vmask[i] = 1'b1;
      end else begin : g_none
        assign ack_x[i] = 1'b0;
        assign vmask[i] = 1'b0;
      end
    end
  endgenerate

  assign wr_cmd    = reg_wr && (reg_addr == ADDR_W'(CMD_OFS));
  assign wr_cfg    = reg_wr && (reg_addr == ADDR_W'(CFG_OFS));
  assign start     = wr_cmd && reg_wdata[CMD_UPD_BIT] && (state == ST_RUN);
  assign done      = ack_x[act_src] | ~vmask[act_src];
  assign run_phase = (state == ST_RUN) || (state == ST_ON);
  assign hold      = (state == ST_LOAD);
  assign root_off  = ~|ack_s;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_req
      assign en_req[i] = run_phase && (act_src == SRC_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      upd     <= 1'b0;
      dirty   <= 1'b0;
      wrs     <= 1'b0;
      sh_src  <= '0;
      sh_div  <= DIV_W'(1);
      nsrc    <= '0;
      ndiv    <= DIV_W'(1);
      act_src <= '0;
      act_div <= DIV_W'(1);
    end else begin
      if (wr_cfg) begin
        sh_div <= reg_wdata[DIV_SH +: DIV_W];
        sh_src <= reg_wdata[SRC_SH +: SRC_W];
      end
      if (wr_cfg)     wrs <= 1'b1;
      else if (start) wrs <= 1'b0;
      if (wr_cfg)                          dirty <= 1'b1;
      else if ((state == ST_ON) && done)   dirty <= wrs;
      case (state)
        ST_RUN: if (start) begin
          upd   <= 1'b1;
          nsrc  <= sh_src;
          ndiv  <= sh_div;
          state <= ST_OFF;
        end
        ST_OFF: if (root_off) state <= ST_LOAD;
        ST_LOAD: begin
          act_src <= nsrc;
          act_div <= eff_div(ndiv);
          state   <= ST_ON;
        end
        ST_ON: if (done) begin
          upd   <= 1'b0;
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    cmd_v = '0;
    cmd_v[CMD_UPD_BIT]   = upd;
    cmd_v[CMD_DIRTY_BIT] = dirty;
    cmd_v[CMD_OFF_BIT]   = root_off;
    cfg_v = '0;
    cfg_v[DIV_SH +: DIV_W] = sh_div;
    cfg_v[SRC_SH +: SRC_W] = sh_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      if (reg_addr == ADDR_W'(CMD_OFS))      reg_rdata <= cmd_v;
      else if (reg_addr == ADDR_W'(CFG_OFS)) reg_rdata <= cfg_v;
      else                                   reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/cmux_root.sv
module cmux_root
  import cmux_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned DIV_SH = 0,
  parameter int unsigned SRC_SH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              clk_out
);
  logic [NSRC-1:0]  en_req, ack_raw, ack_s, gclk_v;
  logic [DIV_W-1:0] act_div;
  logic             hold, upd, dirty, root_off;
  logic             mux_clk, div_rst_n;

  cmux_regs #(
    .NSRC(NSRC), .DIV_W(DIV_W), .DIV_SH(DIV_SH), .SRC_SH(SRC_SH), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_raw(ack_raw), .en_req(en_req), .ack_s(ack_s),
    .act_div(act_div), .hold(hold), .upd(upd), .dirty(dirty),
    .root_off(root_off)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_lane
      cmux_gate u_gate (
        .sclk(src_clk[i]), .rst_n(rst_n), .en_req(en_req[i]),
        .en_ack(ack_raw[i]), .gclk(gclk_v[i])
      );
    end
  endgenerate

  assign mux_clk   = |gclk_v;
  assign div_rst_n = rst_n & ~hold;

  cmux_hdiv #(.DIV_W(DIV_W)) u_div (
    .clk_in(mux_clk), .arst_n(div_rst_n), .code(act_div), .clk_o(clk_out)
  );
endmodule

// File: rtl/cmux_root_chk.sv
module cmux_root_chk
  import cmux_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NSRC-1:0]   en_req,
  input logic [NSRC-1:0]   ack_s,
  input logic [DIV_W-1:0]  act_div,
  input logic              hold,
  input logic              upd,
  input logic              dirty,
  input logic              root_off
);
  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_req));

  // R7
  one_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ack_s) <= 1);

  // R7
  gap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> root_off);

  // R4
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd) |-> !root_off);

  // R3
  dirty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty) |-> $past(reg_wr && (reg_addr == ADDR_W'(CFG_OFS))));

  // R5
  div_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_s) && $past(|ack_s)) |-> $stable(act_div));
endmodule

bind cmux_root cmux_root_chk #(
  .NSRC(NSRC), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .en_req(en_req), .ack_s(ack_s), .act_div(act_div), .hold(hold),
  .upd(upd), .dirty(dirty), .root_off(root_off)
);

// File: tb/tb_cmux_root.sv
`timescale 1ns/1ps
module tb_cmux_root;
  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NSRC-1:0] src_clk;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // source i has period 10+2i ns
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic sc = 1'b0;
      always #(5 + i) sc = ~sc;
      assign src_clk[i] = sc;
    end
  endgenerate

  cmux_root dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_per(input string req, input string what,
                         input real act, input real exp);
    total++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic measure(output real p);
    real t1, t2;
    @(posedge clk_out);
    @(posedge clk_out);
    t1 = $realtime;
    @(posedge clk_out);
    t2 = $realtime;
    p = t2 - t1;
  endtask

  function automatic real exp_per(input int src, input int code);
    int eff;
    eff = (code == 0) ? 1 : (code == 31) ? 30 : code;
    return (eff + 1) * (10.0 + 2.0 * src) / 2.0;
  endfunction

  // wait for bit 0 to clear; report whether root-stopped was seen meanwhile
  task automatic wait_done(output bit ok, output bit seen_off);
    logic [31:0] d;
    ok = 1'b0; seen_off = 1'b0;
    for (int k = 0; k < 500; k++) begin
      bus_read(4'h0, d);
      if (d[31] && d[0]) seen_off = 1'b1;
      if (!d[0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic commit(output bit ok, output bit seen_off);
    bus_write(4'h0, 32'h1);
    wait_done(ok, seen_off);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    real p;
    repeat (60) @(negedge clk);
    bus_read(4'h0, d);
    chk(d == 32'h0, "R2", "command after reset", d, 32'h0);
    bus_read(4'h4, d);
    chk(d == 32'h001, "R2", "config after reset", d, 32'h001);
    measure(p);
    chk_per("R2", "period after reset", p, exp_per(0, 1));
  endtask

  task automatic t_map();
    logic [31:0] d;
    bus_write(4'h0, 32'h0);
    bus_read(4'h0, d);
    chk(d == 32'h0, "R4", "command after writing 0", d, 32'h0);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, d);
    chk(d == 32'h0, "R1", "unmapped address read", d, 32'h0);
    bus_read(4'h4, d);
    chk(d == 32'h001, "R1", "config after unmapped write", d, 32'h001);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, d);
    chk(d == 32'h71F, "R1", "config field masking", d, 32'h71F);
    bus_write(4'h4, 32'h001);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    real p;
    bit ok, so;
    bus_write(4'h4, 32'h205);
    bus_read(4'h0, d);
    chk(d == 32'h10, "R3", "pending after config write", d, 32'h10);
    measure(p);
    chk_per("R3", "period unchanged before commit", p, exp_per(0, 1));
    commit(ok, so);
    chk(ok, "R4", "commit bit self-clears", ok, 1);
    chk(so, "R7", "root-stopped seen during switch", so, 1);
    bus_read(4'h0, d);
    chk(d == 32'h0, "R9", "pending cleared after commit", d, 32'h0);
    measure(p);
    chk_per("R5", "period src2 code5", p, exp_per(2, 5));
  endtask

  task automatic t_half();
    real p;
    bit ok, so;
    bus_write(4'h4, 32'h102);
    commit(ok, so);
    chk(ok, "R4", "commit src1 code2", ok, 1);
    measure(p);
    chk_per("R5", "period src1 code2 (1.5x)", p, exp_per(1, 2));
    bus_write(4'h4, 32'h304);
    commit(ok, so);
    chk(so, "R7", "root-stopped seen src1->src3", so, 1);
    measure(p);
    chk_per("R5", "period src3 code4 (2.5x)", p, exp_per(3, 4));
    bus_write(4'h4, 32'h30B);
    commit(ok, so);
    measure(p);
    chk_per("R5", "period src3 code11 (6x)", p, exp_per(3, 11));
  endtask

  task automatic t_edge();
    real p;
    bit ok, so;
    bus_write(4'h4, 32'h000);
    commit(ok, so);
    measure(p);
    chk_per("R6", "code 0 acts as pass-through", p, exp_per(0, 0));
    bus_write(4'h4, 32'h41F);
    commit(ok, so);
    measure(p);
    chk_per("R6", "all-ones code acts as 30", p, exp_per(4, 30));
    bus_write(4'h4, 32'h41E);
    commit(ok, so);
    measure(p);
    chk_per("R5", "code 30 period", p, exp_per(4, 30));
  endtask

  task automatic t_busy();
    logic [31:0] d;
    real p;
    bit ok, so;
    bus_write(4'h4, 32'h503);
    bus_write(4'h0, 32'h1);
    bus_write(4'h4, 32'h606);
    bus_write(4'h0, 32'h1);
    bus_read(4'h0, d);
    chk((d & 32'h11) == 32'h11, "R8", "commit and pending while busy", d & 32'h11, 32'h11);
    wait_done(ok, so);
    chk(ok, "R8", "in-flight commit completes", ok, 1);
    bus_read(4'h0, d);
    chk(d == 32'h10, "R8", "pending kept after late write", d, 32'h10);
    bus_read(4'h4, d);
    chk(d == 32'h606, "R8", "staged value holds late write", d, 32'h606);
    measure(p);
    chk_per("R8", "output follows captured setting", p, exp_per(5, 3));
    commit(ok, so);
    bus_read(4'h0, d);
    chk(d == 32'h0, "R9", "pending cleared after second commit", d, 32'h0);
    measure(p);
    chk_per("R8", "late setting applied at next commit", p, exp_per(6, 6));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_stage();
    t_half();
    t_edge();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule